// File: doc/BRIEF.md
# Four-level masked interrupt aggregator

This block gathers device interrupt request lines into four priority levels, numbered 3 through 6, and drives one interrupt line per level toward the processor. Each level has up to four device request inputs. It has a status register that mirrors which of its devices are requesting, and an enable register that masks them. A level's output is asserted while any device is both requesting and enabled.

Software reaches the registers over a small synchronous byte bus with an address, a write strobe, a read strobe, write data and registered read data. Enables are never written as a whole value. A write to an enable register either sets or clears the bits selected in its low nibble, and bit 7 of the written byte picks which. Different drivers can therefore unmask or mask their own device without a read-modify-write sequence.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous reset every enable bit is 0, every irq output is 0, and rd_data is 0.
- R2: A read strobe in one cycle places the addressed register value on rd_data after the next rising clock edge. In any cycle without a read strobe, rd_data returns 0 after the edge. Bits 7:4 of every register read are 0.
- R3: The status register of level L is at address 0x100 + 0x10*L (0x130, 0x140, 0x150, 0x160). Its bit d equals the request input of device d sampled at the previous rising edge. Reading it does not clear it.
- R4: The enable register of level L is at the status address plus 4 (0x134, 0x144, 0x154, 0x164). A read returns the current enable mask in bits 3:0.
- R5: A write to an enable register with data bit 7 = 1 sets each enable bit whose position is 1 in data bits 3:0, and leaves the other enable bits unchanged (0x86 enables devices 1 and 2).
- R6: A write to an enable register with data bit 7 = 0 clears each enable bit whose position is 1 in data bits 3:0, and leaves the other enable bits unchanged (0x02 disables only device 1).
- R7: irq[k] for level 3+k is 1 exactly when the status and enable masks of that level share a set bit. It follows a request or enable change after one rising edge.
- R8: The number of devices per level is 1 for level 3, 4 for level 4, 2 for level 5 and 3 for level 6. Request inputs above that count read as 0 in status, and enable bits above that count cannot be set.
- R9: Reads from any other address return 0. Writes to status registers or to unmapped addresses leave every enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Register byte address for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data; bit 7 selects set or clear, bits 3:0 select devices |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, zero when no read was strobed |
| dev_req | input | 16 | Level-sensitive requests; bits 4k+3..4k belong to level 3+k |
| irq | output | 4 | Per-level interrupt outputs; bit k is level 3+k |

## Verification
A wrong enable bit shows up at the ports in two ways. The level's irq line drops or rises against the expected mask one edge after the request pattern makes that bit matter, and the enable read-back differs one edge after a read strobe. A wrong status bit likewise appears on irq one edge after the request change, if the device is enabled. Set and clear writes are each followed by a read, so a write that disturbs an unselected bit is caught before the next write. Writes to the wrong level, to status addresses or to unmapped addresses are caught the same way, since they would also change an enable.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    parameter int ADDR_W      = 12;
    parameter int DATA_W      = 8;
    parameter int NUM_LEVELS  = 4;
    parameter int FIRST_LEVEL = 3;
    parameter int DEV_MAX     = 4;

    localparam int LVL_W   = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;
    localparam int REQ_W   = NUM_LEVELS * DEV_MAX;
    localparam int OP_BIT  = DATA_W - 1;
    localparam int PAD_W   = DATA_W - DEV_MAX;

    localparam int REG_BASE  = 'h100;
    localparam int STRIDE    = 'h010;
    localparam int EN_OFFSET = 'h004;

    typedef logic [DEV_MAX-1:0] dev_mask_t;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_ENABLE = 2'd2
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t        kind;
        logic [LVL_W-1:0] lvl;
    } dec_t;

    // devices wired on each level, indexed from the first level
    function automatic int dev_count(int idx);
        case (idx)
            0:       return 1;
            1:       return 4;
            2:       return 2;
            3:       return 3;
            default: return DEV_MAX;
        endcase
    endfunction

    function automatic dev_mask_t used_mask(int idx);
        dev_mask_t m;
        m = '0;
        for (int d = 0; d < DEV_MAX; d++) begin
            if (d < dev_count(idx)) m[d] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] status_addr(int idx);
        return ADDR_W'(REG_BASE + STRIDE * (FIRST_LEVEL + idx));
    endfunction

    function automatic logic [ADDR_W-1:0] enable_addr(int idx);
        return ADDR_W'(REG_BASE + STRIDE * (FIRST_LEVEL + idx) + EN_OFFSET);
    endfunction

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.kind = ACC_NONE;
        dec.lvl  = '0;
        for (int k = 0; k < NUM_LEVELS; k++) begin
            if (addr == status_addr(k)) begin
                dec.kind = ACC_STATUS;
                dec.lvl  = LVL_W'(k);
            end else if (addr == enable_addr(k)) begin
                dec.kind = ACC_ENABLE;
                dec.lvl  = LVL_W'(k);
            end
        end
    end

endmodule

// File: rtl/irq_agg_level.sv
module irq_agg_level
    import irq_agg_pkg::*;
#(
    parameter int LVL_IDX = 0
)(
    input  logic      clk,
    input  logic      rst,
    input  dev_mask_t req,
    input  logic      wr_set,
    input  logic      wr_clr,
    input  dev_mask_t wr_mask,
    output dev_mask_t stat_q,
    output dev_mask_t en_q,
    output logic      irq
);

    localparam dev_mask_t USED = used_mask(LVL_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= req & USED;
            if (wr_set)
                en_q <= en_q | (wr_mask & USED);
            else if (wr_clr)
                en_q <= en_q & ~wr_mask;
        end
    end

    assign irq = |(stat_q & en_q);

    AST_SET_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((en_q & $past(en_q)) == $past(en_q))); // R5

    AST_CLR_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((en_q & ~$past(en_q)) == '0)); // R6

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_set && !wr_clr) |=> $stable(en_q)); // R9

    AST_STAT_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q == ($past(req) & USED))); // R3

    AST_UNUSED_EN_LOW: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((en_q & ~USED) == '0)); // R8

endmodule

// File: rtl/irq_agg_readmux.sv
module irq_agg_readmux
    import irq_agg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_en,
    input  dec_t                       dec,
    input  dev_mask_t [NUM_LEVELS-1:0] stat_all,
    input  dev_mask_t [NUM_LEVELS-1:0] en_all,
    output logic      [DATA_W-1:0]     rd_data
);

    dev_mask_t sel;

    always_comb begin
        case (dec.kind)
            ACC_STATUS: sel = stat_all[dec.lvl];
            ACC_ENABLE: sel = en_all[dec.lvl];
            default:    sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= {{PAD_W{1'b0}}, sel};
        else
            rd_data <= '0;
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0)); // R2

    AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.kind == ACC_NONE) |=> (rd_data == '0)); // R9

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [REQ_W-1:0]  dev_req,
    output logic [NUM_LEVELS-1:0] irq
);

    dec_t                       dec;
    dev_mask_t [NUM_LEVELS-1:0] stat_all;
    dev_mask_t [NUM_LEVELS-1:0] en_all;
    logic      [NUM_LEVELS-1:0] lvl_wr;
    dev_mask_t                  wr_mask;
    logic                       wr_is_set;

    assign wr_mask   = wr_data[DEV_MAX-1:0];
    assign wr_is_set = wr_data[OP_BIT];

    irq_agg_decode u_decode (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
        assign lvl_wr[k] = wr_en && (dec.kind == ACC_ENABLE) &&
                           (dec.lvl == LVL_W'(k));

        irq_agg_level #(.LVL_IDX(k)) u_level (
            .clk     (clk),
            .rst     (rst),
            .req     (dev_req[k*DEV_MAX +: DEV_MAX]),
            .wr_set  (lvl_wr[k] && wr_is_set),
            .wr_clr  (lvl_wr[k] && !wr_is_set),
            .wr_mask (wr_mask),
            .stat_q  (stat_all[k]),
            .en_q    (en_all[k]),
            .irq     (irq[k])
        );
    end

    irq_agg_readmux u_readmux (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .dec      (dec),
        .stat_all (stat_all),
        .en_all   (en_all),
        .rd_data  (rd_data)
    );

    AST_ONE_LEVEL_WR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lvl_wr)); // R9

    AST_NONEN_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.kind != ACC_ENABLE) |=> $stable(en_all)); // R9

endmodule

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;

    localparam int CLK_NS = 20;
    localparam int NVEC   = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] addr;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic [15:0] dev_req;
    logic [3:0]  irq;

    int checks   = 0;
    int failures = 0;

    always #(CLK_NS/2) clk = ~clk;

    irq_agg_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .dev_req (dev_req),
        .irq     (irq)
    );

    // {req[15:0], waddr[11:0], wdata[7:0], raddr[11:0], exp_rd[7:0], exp_irq[3:0]}
    // waddr of 0 means no write in that step; state carries over between steps
    localparam logic [59:0] VEC [NVEC] = '{
        {16'h0000, 12'h134, 8'h81, 12'h134, 8'h01, 4'b0000}, // R5 enable L3 dev0
        {16'h0001, 12'h000, 8'h00, 12'h130, 8'h01, 4'b0001}, // R3 R7
        {16'h00F0, 12'h144, 8'h86, 12'h144, 8'h06, 4'b0010}, // R5 0x86 -> devs 1,2
        {16'h0090, 12'h000, 8'h00, 12'h140, 8'h09, 4'b0000}, // R7 no overlap
        {16'h0090, 12'h144, 8'h89, 12'h144, 8'h0F, 4'b0010}, // R5 keeps 1,2
        {16'h0090, 12'h144, 8'h02, 12'h144, 8'h0D, 4'b0010}, // R6 0x02 -> dev1 only
        {16'h0090, 12'h144, 8'h09, 12'h144, 8'h04, 4'b0000}, // R6 clears 0,3
        {16'hF000, 12'h164, 8'h8F, 12'h160, 8'h07, 4'b1000}, // R8 L6 three devs
        {16'hF000, 12'h000, 8'h00, 12'h164, 8'h07, 4'b1000}, // R8 R4
        {16'h0F00, 12'h154, 8'h8C, 12'h154, 8'h00, 4'b0000}, // R8 unused enables
        {16'h0F00, 12'h154, 8'h83, 12'h150, 8'h03, 4'b0100}, // R8 L5 two devs
        {16'h0F00, 12'h150, 8'h00, 12'h154, 8'h03, 4'b0100}, // R9 status write
        {16'h0F00, 12'h138, 8'h00, 12'h138, 8'h00, 4'b0100}, // R9 unmapped
        {16'h0F00, 12'h174, 8'h0F, 12'h174, 8'h00, 4'b0100}, // R9 beyond last level
        {16'hFFFF, 12'h000, 8'h00, 12'h130, 8'h01, 4'b1111}, // R7 R8 all levels
        {16'hFFFF, 12'h000, 8'h00, 12'h130, 8'h01, 4'b1111}  // R3 read not clearing
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // leaves the clock at the negedge after the read data is registered
    task automatic read_reg(logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        #(CLK_NS * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        dev_req = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, requests active but nothing enabled
        check("R1 irq after reset", irq, 4'b0000);
        check("R1 rd_data after reset", rd_data, 8'h00);
        for (int k = 0; k < 4; k++) begin
            read_reg(12'h134 + 12'(k * 16), rv);
            check("R1 enable after reset", rv, 8'h00);
        end
        dev_req = 16'h0000;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [59:0] v;
            v = VEC[i];
            @(negedge clk);
            dev_req = v[59:44];
            if (v[43:32] != 12'h000) begin
                addr = v[43:32]; wr_data = v[31:24]; wr_en = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0;
            addr = v[23:12]; rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            check($sformatf("R3 R4 R5 R6 R8 R9 vec%0d read", i), rd_data, v[11:4]);
            check($sformatf("R7 vec%0d irq", i), irq, v[3:0]);
        end

        // R2: read data clears the cycle after a strobe-free edge
        @(negedge clk);
        check("R2 rd_data idle zero", rd_data, 8'h00);

        // R7: one-edge latency of irq after a request change
        // at this point every level has enables that overlap all-ones requests
        dev_req = 16'h0000;
        #1;
        check("R7 irq before edge", irq, 4'b1111);
        @(negedge clk);
        check("R7 irq after edge", irq, 4'b0000);

        // R7: one-edge latency after an enable write
        dev_req = 16'h0001;
        @(negedge clk);
        check("R7 irq with L3 enabled", irq, 4'b0001);
        addr = 12'h134; wr_data = 8'h01; wr_en = 1'b1;
        #1;
        check("R7 irq before clear edge", irq, 4'b0001);
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 R7 irq after clear", irq, 4'b0000);

        // R2: upper bits zero on status read with all requests high
        dev_req = 16'hFFFF;
        read_reg(12'h140, rv);
        check("R2 upper bits zero", rv, 8'h0F);

        // R1: reset mid-run clears enables
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after second reset", irq, 4'b0000);
        read_reg(12'h144, rv);
        check("R1 L4 enable after second reset", rv, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule